// File: doc/BRIEF.md
# Multiplexed Pixel Demultiplexer

This block sits behind a 12-bit video input port. The source sends each 24-bit pixel as two 12-bit half-words, one after the other. The block rebuilds one full pixel per pixel period and presents it with a valid strobe. The frame timing (data enable, horizontal sync and vertical sync) is delayed so that it lines up with that strobe.

There are three capture modes:
- **Dual-edge.** The clock runs at the pixel rate. One half is taken on the rising edge and the other on the falling edge.
- **Single-edge.** The clock runs at twice the pixel rate. Every half is taken on one edge, rising or falling as configured.
- **Ganged.** Two 12-bit ports are read together as one 24-bit word on every rising edge. Only the timing inputs of the first port are used.

Two flags come out with the pixels. The panel-active flag is the delayed data enable. The TV-active flag rises once a programmable number of pixels have been delivered since the leading edge of horizontal sync. It then stays high until the next horizontal sync.

The mode and edge select are taken from the configuration inputs only while vertical sync is high. A frame therefore never changes capture mode partway through.

Top module: `mpx_pixel_demux`

## Requirements
- R1: While `rst_ni` is low, `pix_o`, `valid_o`, `hs_o`, `vs_o`, `panel_act_o` and `tv_act_o` are all zero, and the active mode is dual-edge with rising-edge select.
- R2: In dual-edge mode (code 2'b00), a rising edge that samples `de_i` high starts a pixel. The pixel is presented after the next rising edge as `{word at the falling edge between the two, word at the first rising edge}`, with `valid_o` high for one cycle.
- R3: In single-edge mode (code 2'b01), words are taken on the rising edge when the edge bit is 0 and on the falling edge when it is 1. After `de_i` rises, the first word is the low half and the second word is the high half. The pixel and `valid_o` appear after the rising edge that samples the second word (in falling-edge select, the first rising edge after it). `valid_o` is never high in two cycles in a row.
- R4: In single-edge mode, a word taken with `de_i` low restarts the pairing. An unpaired low half is dropped, and the next word taken with `de_i` high becomes a new low half.
- R5: In ganged mode (code 2'b10), each rising edge with `de_i` high yields `{d2_i, d1_i}` after that edge, with `valid_o` high.
- R6: `hs_o`, `vs_o` and `panel_act_o` carry `hs_i`, `vs_i` and `de_i` with the same delay as the pixel path:
  - dual-edge: two rising edges;
  - single-edge rising and ganged: one rising edge;
  - single-edge falling: the falling-edge sample, shown after the next rising edge.
  
  `valid_o` implies `panel_act_o`.
- R7: Outside ganged mode, `d2_i` has no effect on any output.
- R8: While `valid_o` is low, `pix_o` holds the last pixel delivered.
- R9: The pixel count is counted on the outputs and is cleared by a rising `hs_o`; a strobe in the same cycle as a rising `hs_o` is not counted. When a strobe's 0-based index within the line is at least `cfg_sav_i`, `tv_act_o` is high from the next cycle. The flag is cleared in the cycle after `hs_o` rises, and otherwise stays high.
- R10: The mode and edge select are loaded only on a rising edge that samples `vs_i` high. Mode code 2'b11 is ignored, and the previous mode and edge select are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input word clock (pixel rate or twice the pixel rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| d1_i | input | HALF_W | Multiplexed data port; low half in ganged mode |
| d2_i | input | HALF_W | Second data port; high half in ganged mode only |
| de_i | input | 1 | Data enable |
| hs_i | input | 1 | Horizontal sync, active high |
| vs_i | input | 1 | Vertical sync, active high; also opens the configuration window |
| cfg_mode_i | input | 2 | Capture mode: 00 dual-edge, 01 single-edge, 10 ganged, 11 ignored |
| cfg_fall_i | input | 1 | Edge select for single-edge mode: 0 rising, 1 falling |
| cfg_sav_i | input | CNT_W | Start-of-active-video pixel index |
| pix_o | output | 2*HALF_W | Rebuilt pixel |
| valid_o | output | 1 | One-cycle strobe marking a new pixel |
| hs_o | output | 1 | Horizontal sync aligned to the pixel path |
| vs_o | output | 1 | Vertical sync aligned to the pixel path |
| panel_act_o | output | 1 | Data enable aligned to the pixel path |
| tv_act_o | output | 1 | Active TV video flag |

## Verification
A pairing phase that is stuck or inverted swaps the halves of `pix_o`, or shifts `valid_o` by one word. This shows on the first pixel of the next line, and within one glitch-word in the glitch test. A bad configuration latch selects the wrong source edge or the wrong port. Every pixel after the vertical-blank window then differs from the reference, so the first strobe of the following line exposes it. A line counter that drifts or fails to clear moves the rising edge of `tv_act_o` away from the strobe whose index equals `cfg_sav_i`. It also leaves the flag high across `hs_o`, which is visible within two cycles of the sync edge.

// File: rtl/mpx_pkg.sv
`timescale 1ns/1ps
package mpx_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL   = 2'b00,
        MODE_SINGLE = 2'b01,
        MODE_GANG   = 2'b10
    } mode_e;

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } tim_t;

endpackage

// File: rtl/mpx_neg_capture.sv
`timescale 1ns/1ps
// Falling-edge sampler for the half-word and its timing bits.
module mpx_neg_capture #(
    parameter int unsigned HALF_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [HALF_W-1:0] d_i,
    input  mpx_pkg::tim_t     tim_i,
    output logic [HALF_W-1:0] d_o,
    output mpx_pkg::tim_t     tim_o
);
    typedef struct packed {
        logic [HALF_W-1:0] d;
        mpx_pkg::tim_t     t;
    } neg_t;

    neg_t neg_d, neg_q;

    always_comb begin
        neg_d   = neg_q;
        neg_d.d = d_i;
        neg_d.t = tim_i;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) neg_q <= '0;
        else         neg_q <= neg_d;
    end

    assign d_o   = neg_q.d;
    assign tim_o = neg_q.t;
endmodule

// File: rtl/mpx_cfg_latch.sv
`timescale 1ns/1ps
// Loads mode and edge select only inside vertical blanking.
module mpx_cfg_latch (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          vs_i,
    input  logic [1:0]    mode_i,
    input  logic          fall_i,
    output mpx_pkg::mode_e mode_o,
    output logic          fall_o
);
    typedef struct packed {
        mpx_pkg::mode_e mode;
        logic           fall;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (vs_i && (mode_i != 2'b11)) begin
            cfg_d.mode = mpx_pkg::mode_e'(mode_i);
            cfg_d.fall = fall_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '{mode: mpx_pkg::MODE_DUAL, fall: 1'b0};
        else         cfg_q <= cfg_d;
    end

    assign mode_o = cfg_q.mode;
    assign fall_o = cfg_q.fall;
endmodule

// File: rtl/mpx_pair_core.sv
`timescale 1ns/1ps
// Joins half-words into pixels and delays timing to match.
module mpx_pair_core #(
    parameter int unsigned HALF_W = 12,
    localparam int unsigned PIX_W = 2 * HALF_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  mpx_pkg::mode_e    mode_i,
    input  logic [HALF_W-1:0] cw_i,
    input  mpx_pkg::tim_t     ctim_i,
    input  logic [HALF_W-1:0] hi_i,
    input  logic [HALF_W-1:0] d2_i,
    output logic [PIX_W-1:0]  pix_o,
    output logic              valid_o,
    output mpx_pkg::tim_t     tim_o
);
    import mpx_pkg::*;

    typedef struct packed {
        logic [HALF_W-1:0] lo;
        logic              phase;
        tim_t              st;
        logic [PIX_W-1:0]  pix;
        logic              valid;
        tim_t              ot;
    } pair_t;

    pair_t pr_d, pr_q;

    always_comb begin
        pr_d       = pr_q;
        pr_d.valid = 1'b0;
        pr_d.st    = ctim_i;
        unique case (mode_i)
            MODE_DUAL: begin
                pr_d.lo    = cw_i;
                pr_d.phase = 1'b0;
                pr_d.ot    = pr_q.st;
                if (pr_q.st.de) begin
                    pr_d.pix   = {hi_i, pr_q.lo};
                    pr_d.valid = 1'b1;
                end
            end
            MODE_SINGLE: begin
                pr_d.ot = ctim_i;
                if (!ctim_i.de) begin
                    pr_d.phase = 1'b0;
                end else if (!pr_q.phase || !pr_q.st.de) begin
                    pr_d.lo    = cw_i;
                    pr_d.phase = 1'b1;
                end else begin
                    pr_d.pix   = {cw_i, pr_q.lo};
                    pr_d.valid = 1'b1;
                    pr_d.phase = 1'b0;
                end
            end
            default: begin
                pr_d.ot    = ctim_i;
                pr_d.phase = 1'b0;
                if (ctim_i.de) begin
                    pr_d.pix   = {d2_i, cw_i};
                    pr_d.valid = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pr_q <= '0;
        else         pr_q <= pr_d;
    end

    assign pix_o   = pr_q.pix;
    assign valid_o = pr_q.valid;
    assign tim_o   = pr_q.ot;
endmodule

// File: rtl/mpx_line_timer.sv
`timescale 1ns/1ps
// Counts delivered pixels per line and raises the TV-active flag.
module mpx_line_timer #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hs_i,
    input  logic             valid_i,
    input  logic [CNT_W-1:0] sav_i,
    output logic             tv_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hsp;
        logic             tv;
    } lt_t;

    lt_t lt_d, lt_q;

    always_comb begin
        lt_d     = lt_q;
        lt_d.hsp = hs_i;
        if (hs_i && !lt_q.hsp) begin
            lt_d.cnt = '0;
            lt_d.tv  = 1'b0;
        end else if (valid_i) begin
            if (lt_q.cnt >= sav_i) lt_d.tv = 1'b1;
            if (lt_q.cnt != '1)    lt_d.cnt = lt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lt_q <= '0;
        else         lt_q <= lt_d;
    end

    assign tv_o = lt_q.tv;
endmodule

// File: rtl/mpx_pixel_demux.sv
`timescale 1ns/1ps
module mpx_pixel_demux #(
    parameter int unsigned HALF_W = 12,
    parameter int unsigned CNT_W  = 12,
    localparam int unsigned PIX_W = 2 * HALF_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [HALF_W-1:0] d1_i,
    input  logic [HALF_W-1:0] d2_i,
    input  logic              de_i,
    input  logic              hs_i,
    input  logic              vs_i,
    input  logic [1:0]        cfg_mode_i,
    input  logic              cfg_fall_i,
    input  logic [CNT_W-1:0]  cfg_sav_i,
    output logic [PIX_W-1:0]  pix_o,
    output logic              valid_o,
    output logic              hs_o,
    output logic              vs_o,
    output logic              panel_act_o,
    output logic              tv_act_o
);
    import mpx_pkg::*;

    tim_t              tim_in, neg_tim, cur_tim, out_tim;
    logic [HALF_W-1:0] neg_word, cur_word;
    mode_e             mode_q;
    logic              fall_q;
    logic              use_neg;

    assign tim_in.de = de_i;
    assign tim_in.hs = hs_i;
    assign tim_in.vs = vs_i;

    mpx_neg_capture #(.HALF_W(HALF_W)) neg_cap_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (d1_i),
        .tim_i  (tim_in),
        .d_o    (neg_word),
        .tim_o  (neg_tim)
    );

    mpx_cfg_latch cfg_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .vs_i   (vs_i),
        .mode_i (cfg_mode_i),
        .fall_i (cfg_fall_i),
        .mode_o (mode_q),
        .fall_o (fall_q)
    );

    // Single-edge falling select takes its words from the falling-edge sampler.
    assign use_neg  = (mode_q == MODE_SINGLE) && fall_q;
    assign cur_word = use_neg ? neg_word : d1_i;
    assign cur_tim  = use_neg ? neg_tim  : tim_in;

    mpx_pair_core #(.HALF_W(HALF_W)) pair_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .mode_i  (mode_q),
        .cw_i    (cur_word),
        .ctim_i  (cur_tim),
        .hi_i    (neg_word),
        .d2_i    (d2_i),
        .pix_o   (pix_o),
        .valid_o (valid_o),
        .tim_o   (out_tim)
    );

    assign hs_o        = out_tim.hs;
    assign vs_o        = out_tim.vs;
    assign panel_act_o = out_tim.de;

    mpx_line_timer #(.CNT_W(CNT_W)) timer_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hs_i    (hs_o),
        .valid_i (valid_o),
        .sav_i   (cfg_sav_i),
        .tv_o    (tv_act_o)
    );
endmodule

// File: rtl/mpx_pixel_demux_chk.sv
`timescale 1ns/1ps
module mpx_pixel_demux_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       vs_i,
    input logic [1:0] mode_q,
    input logic       valid_o,
    input logic       hs_o,
    input logic       panel_act_o,
    input logic       tv_act_o
);
    // R9
    tv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hs_o) |=> !tv_act_o);

    // R9
    tv_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tv_act_o && !$rose(hs_o)) |=> tv_act_o);

    // R10
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vs_i |=> $stable(mode_q));

    // R6
    valid_in_de_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> panel_act_o);

    // R3
    single_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && mode_q == 2'b01) |=> !valid_o);
endmodule

bind mpx_pixel_demux mpx_pixel_demux_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vs_i        (vs_i),
    .mode_q      (mode_q),
    .valid_o     (valid_o),
    .hs_o        (hs_o),
    .panel_act_o (panel_act_o),
    .tv_act_o    (tv_act_o)
);

// File: tb/mpx_pixel_demux_tb_top.sv
`timescale 1ns/1ps
module mpx_pixel_demux_tb_top;
    localparam int HW = 12;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [HW-1:0] d1 = '0, d2 = '0;
    logic de = 1'b0, hs = 1'b0, vs = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic cfg_fall = 1'b0;
    logic [CW-1:0] cfg_sav = 12'd2;
    logic [2*HW-1:0] pix;
    logic valid, hs_q, vs_q, pact, tv;

    int checks = 0;
    int errors = 0;
    string tag_pix = "R2";
    int b_mode = 0;

    always #10 clk = ~clk; // 50 MHz

    mpx_pixel_demux #(.HALF_W(HW), .CNT_W(CW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .d1_i(d1), .d2_i(d2),
        .de_i(de), .hs_i(hs), .vs_i(vs),
        .cfg_mode_i(cfg_mode), .cfg_fall_i(cfg_fall), .cfg_sav_i(cfg_sav),
        .pix_o(pix), .valid_o(valid), .hs_o(hs_q), .vs_o(vs_q),
        .panel_act_o(pact), .tv_act_o(tv)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // falling-edge samples seen by the model
    logic [HW-1:0] n_d1 = '0;
    logic n_de = 0, n_hs = 0, n_vs = 0;
    always @(negedge clk) begin
        if (!rst_n) begin n_d1 = '0; n_de = 0; n_hs = 0; n_vs = 0; end
        else begin n_d1 = d1; n_de = de; n_hs = hs; n_vs = vs; end
    end

    // reference model state
    logic [2*HW-1:0] e_pix = '0;
    logic e_valid = 0, e_hs = 0, e_vs = 0, e_de = 0, e_tv = 0, last_hs = 0;
    int m_mode = 0;
    logic m_fall = 0;
    logic [HW-1:0] pp_d1 = '0, m_lo = '0;
    logic pp_de = 0, pp_hs = 0, pp_vs = 0;
    int run = 0;
    int lcnt = 0;

    initial begin
        forever begin
            logic [HW-1:0] p_d1, p_d2, s_d;
            logic p_de, p_hs, p_vs, s_de, s_hs, s_vs, nv;
            logic [1:0] p_mode;
            logic p_fall;
            int p_sav;
            string ctag;
            @(posedge clk);
            p_d1 = d1; p_d2 = d2; p_de = de; p_hs = hs; p_vs = vs;
            p_mode = cfg_mode; p_fall = cfg_fall; p_sav = int'(cfg_sav);
            if (!rst_n) begin
                e_pix = '0; e_valid = 0; e_hs = 0; e_vs = 0; e_de = 0; e_tv = 0;
                last_hs = 0; m_mode = 0; m_fall = 0; pp_d1 = '0; pp_de = 0;
                pp_hs = 0; pp_vs = 0; run = 0; lcnt = 0; m_lo = '0;
            end else begin
                // TV flag from the outputs visible before this edge
                if (e_hs && !last_hs) begin lcnt = 0; e_tv = 0; end
                else if (e_valid) begin
                    if (lcnt >= p_sav) e_tv = 1;
                    if (lcnt < 4095) lcnt++;
                end
                last_hs = e_hs;
                nv = 0;
                if (m_mode == 0) begin
                    run = 0;
                    nv = pp_de;
                    if (pp_de) e_pix = {n_d1, pp_d1};
                    e_hs = pp_hs; e_vs = pp_vs; e_de = pp_de;
                end else if (m_mode == 1) begin
                    s_d = m_fall ? n_d1 : p_d1;
                    s_de = m_fall ? n_de : p_de;
                    s_hs = m_fall ? n_hs : p_hs;
                    s_vs = m_fall ? n_vs : p_vs;
                    e_hs = s_hs; e_vs = s_vs; e_de = s_de;
                    if (s_de) begin
                        run++;
                        if (run % 2 == 1) m_lo = s_d;
                        else begin e_pix = {s_d, m_lo}; nv = 1; end
                    end else run = 0;
                end else begin
                    run = 0;
                    nv = p_de;
                    if (p_de) e_pix = {p_d2, p_d1};
                    e_hs = p_hs; e_vs = p_vs; e_de = p_de;
                end
                e_valid = nv;
                if (p_vs && p_mode != 2'b11) begin m_mode = int'(p_mode); m_fall = p_fall; end
                pp_d1 = p_d1; pp_de = p_de; pp_hs = p_hs; pp_vs = p_vs;
            end
            #2;
            ctag = rst_n ? tag_pix : "R1";
            chk(valid === e_valid, ctag, "valid", 32'(valid), 32'(e_valid));
            if (e_valid) chk(pix === e_pix, ctag, "pix", 32'(pix), 32'(e_pix));
            else chk(pix === e_pix, rst_n ? "R8" : "R1", "pix hold", 32'(pix), 32'(e_pix));
            chk(hs_q === e_hs, rst_n ? "R6" : "R1", "hs", 32'(hs_q), 32'(e_hs));
            chk(vs_q === e_vs, rst_n ? "R6" : "R1", "vs", 32'(vs_q), 32'(e_vs));
            chk(pact === e_de, rst_n ? "R6" : "R1", "panel", 32'(pact), 32'(e_de));
            chk(tv === e_tv, rst_n ? "R9" : "R1", "tv", 32'(tv), 32'(e_tv));
        end
    end

    // one clock: rising-edge values, then falling-edge values; t = {vs,hs,de}
    task automatic cyc(input logic [2:0] t);
        @(negedge clk); #4;
        d1 = HW'($urandom); d2 = HW'($urandom); {vs, hs, de} = t;
        @(posedge clk); #4;
        d1 = HW'($urandom); d2 = HW'($urandom); {vs, hs, de} = t;
    endtask

    task automatic line(input int npix, input int glitch);
        int nw;
        nw = (b_mode == 1) ? 2 * npix : npix;
        repeat (2) cyc(3'b010);
        repeat (3) cyc(3'b000);
        for (int i = 0; i < nw; i++) cyc((i == glitch) ? 3'b000 : 3'b001);
        repeat (3) cyc(3'b000);
    endtask

    task automatic setcfg(input logic [1:0] m, input logic f);
        cfg_mode = m; cfg_fall = f;
        repeat (3) cyc(3'b100);
        repeat (2) cyc(3'b000);
        if (m != 2'b11) b_mode = int'(m);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #4 rst_n = 1'b1;
        // R2 dual-edge, R6/R9 checked every clock
        tag_pix = "R2";
        line(8, -1);
        line(6, -1);
        // R3 single-edge rising
        setcfg(2'b01, 1'b0);
        tag_pix = "R3";
        line(7, -1);
        // R4 DE glitch after an odd word
        tag_pix = "R4";
        line(6, 3);
        line(6, 6);
        // R7 port 2 noise outside ganged mode
        tag_pix = "R7";
        line(5, -1);
        // R10 mode change outside vertical blanking ignored
        cfg_mode = 2'b10;
        tag_pix = "R10";
        line(5, -1);
        // R3 single-edge falling
        setcfg(2'b01, 1'b1);
        tag_pix = "R3";
        line(7, -1);
        // R10 reserved code ignored
        setcfg(2'b11, 1'b0);
        tag_pix = "R10";
        line(6, 4);
        // R5 ganged
        setcfg(2'b10, 1'b0);
        tag_pix = "R5";
        line(8, -1);
        // R9 start index 0 and 5
        cfg_sav = 12'd0;
        line(4, -1);
        cfg_sav = 12'd5;
        line(9, -1);
        // back to dual-edge
        setcfg(2'b00, 1'b0);
        tag_pix = "R2";
        line(7, -1);
        repeat (4) cyc(3'b000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule